// File: doc/BRIEF.md
# Scaled-Length Predicate Mask Expander

This block turns one predicate register value into a per-element enable mask for a vector operation whose length is set by a short length code. The code either names a fixed length that ignores the current vector length (VL), or scales VL by a factor k. When VL is scaled by k, each predicate bit enables a contiguous group of k elements. This lets a multi-component operation, such as a four-lane vector per logical element, be masked one logical element at a time. An invert flag complements the predicate before it is used, so a single predicate register can drive both arms of a masked if/else.

The caller presents the predicate, invert flag, VL and length code, and pulses `start` for one cycle. One cycle later the element count, the enable mask and an overflow flag appear together with a one-cycle `valid` pulse. The outputs then hold until the next start. A length that would exceed the supported maximum is clamped, and the clamp is reported.

Top module: `pmask_expand`

## Requirements
- R1: The length code selects the raw element count: 3'b000 gives 1, 3'b001 gives VL, 3'b010 gives 2·VL, 3'b011 gives 3·VL, 3'b100 gives 4·VL, 3'b101 gives 8·VL, 3'b110 gives 16·VL, and 3'b111 gives 4 whatever VL is.
- R2: For the codes that scale VL by k, mask bit e (below the count) equals effective predicate bit floor(e/k).
- R3: For the fixed codes 3'b000 and 3'b111, mask bit e (below the count) equals effective predicate bit e.
- R4: When `pred_inv` is 1, the effective predicate is the bitwise complement of `pred`. Otherwise it is `pred` unchanged.
- R5: Every mask bit at or above `elem_count` is 0. In particular, VL = 0 with a scaling code gives count 0 and an all-zero mask.
- R6: When the raw count exceeds MAX_LEN (64 by default), `elem_count` equals MAX_LEN and `len_ovf` is 1. Otherwise `len_ovf` is 0 and `elem_count` is the raw count.
- R7: `valid` is 1 exactly in the cycle after a cycle with `start` high. The results of that start appear in the same cycle. `elem_count`, `elem_mask` and `len_ovf` do not change in cycles that follow a cycle without `start`.
- R8: After reset, `valid`, `elem_count`, `elem_mask` and `len_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Accepts the request inputs this cycle |
| pred | input | PRED_W (64) | Predicate register value |
| pred_inv | input | 1 | Complement the predicate before expansion |
| vl | input | VL_W (7) | Current vector length |
| len_code | input | 3 | Length code (see R1) |
| valid | output | 1 | One-cycle pulse when results are updated |
| elem_count | output | CNT_W (7) | Total element count after clamping |
| elem_mask | output | MAX_LEN (64) | Element enable mask, bit e enables element e |
| len_ovf | output | 1 | Raw length exceeded MAX_LEN and was clamped |

## Verification
The hardest case to reach is a mask where grouping, inversion and the count cut-off all act on the same output. The hardest such case is a non-power-of-two factor such as 3, where group boundaries fall at odd element indices. The same request must also sit near or past the clamp point, so that a group is cut part-way by the 64-element limit. The stimulus reaches this with directed requests at the clamp edge (for example VL = 21 and 22 with factor 3, and VL = 4 and 5 with factor 16). Random requests are weighted so that VL often lands in the band where scaled lengths cross 64. Each result is compared against an independent element-by-element model.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

  // Length code encoding; the order is behaviour (see R1).
  typedef enum logic [2:0] {
    LC_ONE  = 3'b000,
    LC_VL1  = 3'b001,
    LC_VL2  = 3'b010,
    LC_VL3  = 3'b011,
    LC_VL4  = 3'b100,
    LC_VL8  = 3'b101,
    LC_VL16 = 3'b110,
    LC_FIX4 = 3'b111
  } len_code_e;

  localparam int SCALE_W = 5;

  // Group size selector used by the mask spreader.
  typedef enum logic [2:0] {
    GS_1, GS_2, GS_3, GS_4, GS_8, GS_16
  } grp_sel_e;

endpackage

// File: rtl/pmask_len.sv
module pmask_len
  import pmask_pkg::*;
#(
  parameter int VL_W    = 7,
  parameter int MAX_LEN = 64,
  localparam int CNT_W  = $clog2(MAX_LEN + 1),
  localparam int RAW_W  = VL_W + SCALE_W
) (
  input  logic [2:0]       len_code,
  input  logic [VL_W-1:0]  vl,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output grp_sel_e         grp
);

  logic [SCALE_W-1:0] scale;
  logic               fixed;
  logic [RAW_W-1:0]   fixed_len;
  logic [RAW_W-1:0]   raw;

  always_comb begin
    scale     = SCALE_W'(1);
    fixed     = 1'b0;
    fixed_len = RAW_W'(1);
    grp       = GS_1;
    unique case (len_code_e'(len_code))
      LC_ONE:  begin fixed = 1'b1; fixed_len = RAW_W'(1); end
      LC_VL1:  begin scale = SCALE_W'(1);  grp = GS_1;  end
      LC_VL2:  begin scale = SCALE_W'(2);  grp = GS_2;  end
      LC_VL3:  begin scale = SCALE_W'(3);  grp = GS_3;  end
      LC_VL4:  begin scale = SCALE_W'(4);  grp = GS_4;  end
      LC_VL8:  begin scale = SCALE_W'(8);  grp = GS_8;  end
      LC_VL16: begin scale = SCALE_W'(16); grp = GS_16; end
      LC_FIX4: begin fixed = 1'b1; fixed_len = RAW_W'(4); end
      default: begin fixed = 1'b1; fixed_len = RAW_W'(1); end
    endcase
  end

  always_comb begin
    raw = fixed ? fixed_len : (RAW_W'(vl) * RAW_W'(scale));
    ovf = raw > RAW_W'(MAX_LEN);
    cnt = ovf ? CNT_W'(MAX_LEN) : raw[CNT_W-1:0];
  end

endmodule

// File: rtl/pmask_spread.sv
module pmask_spread
  import pmask_pkg::*;
#(
  parameter int PRED_W  = 64,
  parameter int MAX_LEN = 64,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic [PRED_W-1:0]  pred_eff,
  input  grp_sel_e           grp,
  input  logic [CNT_W-1:0]   cnt,
  output logic [MAX_LEN-1:0] mask
);

  function automatic logic pick(input logic [PRED_W-1:0] v, input int idx);
    logic [PRED_W-1:0] s;
    s = v >> idx;
    return s[0];
  endfunction

  for (genvar e = 0; e < MAX_LEN; e++) begin : g_elem
    logic bit_sel;
    always_comb begin
      unique case (grp)
        GS_1:    bit_sel = pick(pred_eff, e);
        GS_2:    bit_sel = pick(pred_eff, e / 2);
        GS_3:    bit_sel = pick(pred_eff, e / 3);
        GS_4:    bit_sel = pick(pred_eff, e / 4);
        GS_8:    bit_sel = pick(pred_eff, e / 8);
        GS_16:   bit_sel = pick(pred_eff, e / 16);
        default: bit_sel = 1'b0;
      endcase
    end
    assign mask[e] = bit_sel && (CNT_W'(e) < cnt);
  end

endmodule

// File: rtl/pmask_expand.sv
module pmask_expand
  import pmask_pkg::*;
#(
  parameter int PRED_W  = 64,
  parameter int VL_W    = 7,
  parameter int MAX_LEN = 64,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PRED_W-1:0]  pred,
  input  logic               pred_inv,
  input  logic [VL_W-1:0]    vl,
  input  logic [2:0]         len_code,
  output logic               valid,
  output logic [CNT_W-1:0]   elem_count,
  output logic [MAX_LEN-1:0] elem_mask,
  output logic               len_ovf
);

  // Reset release synchronizer.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [PRED_W-1:0] pred_eff;
  logic [CNT_W-1:0]  cnt_d;
  logic              ovf_d;
  grp_sel_e          grp;
  logic [MAX_LEN-1:0] mask_d;

  assign pred_eff = pred_inv ? ~pred : pred;

  pmask_len #(.VL_W(VL_W), .MAX_LEN(MAX_LEN)) u_len (
    .len_code (len_code),
    .vl       (vl),
    .cnt      (cnt_d),
    .ovf      (ovf_d),
    .grp      (grp)
  );

  pmask_spread #(.PRED_W(PRED_W), .MAX_LEN(MAX_LEN)) u_spread (
    .pred_eff (pred_eff),
    .grp      (grp),
    .cnt      (cnt_d),
    .mask     (mask_d)
  );

  // Next-state logic with explicit load enable.
  logic [CNT_W-1:0]   cnt_n;
  logic [MAX_LEN-1:0] mask_n;
  logic               ovf_n;
  always_comb begin
    cnt_n  = elem_count;
    mask_n = elem_mask;
    ovf_n  = len_ovf;
    if (start) begin
      cnt_n  = cnt_d;
      mask_n = mask_d;
      ovf_n  = ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid      <= 1'b0;
      elem_count <= '0;
      elem_mask  <= '0;
      len_ovf    <= 1'b0;
    end else begin
      valid      <= start;
      elem_count <= cnt_n;
      elem_mask  <= mask_n;
      len_ovf    <= ovf_n;
    end
  end

endmodule

// File: rtl/pmask_chk.sv
module pmask_chk #(
  parameter int MAX_LEN = 64,
  parameter int CNT_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [2:0]         len_code,
  input logic               valid,
  input logic [CNT_W-1:0]   elem_count,
  input logic [MAX_LEN-1:0] elem_mask,
  input logic               len_ovf
);

  // R7
  start_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  // R7
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(elem_mask) && $stable(elem_count) && $stable(len_ovf)));

  // R5
  tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_mask >> elem_count) == '0);

  // R6
  ovf_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_ovf |-> (elem_count == CNT_W'(MAX_LEN)));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elem_count <= CNT_W'(MAX_LEN));

  // R1
  single_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_code == 3'b000) |=> (elem_count == CNT_W'(1) && !len_ovf));

  // R1
  fixed_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_code == 3'b111) |=> (elem_count == CNT_W'(4) && !len_ovf));

endmodule

bind pmask_expand pmask_chk #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .len_code   (len_code),
  .valid      (valid),
  .elem_count (elem_count),
  .elem_mask  (elem_mask),
  .len_ovf    (len_ovf)
);

// File: tb/sim_pmask_expand.sv
`timescale 1ns/1ps
module sim_pmask_expand;

  localparam int PRED_W  = 64;
  localparam int VL_W    = 7;
  localparam int MAX_LEN = 64;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start;
  logic [PRED_W-1:0]  pred;
  logic               pred_inv;
  logic [VL_W-1:0]    vl;
  logic [2:0]         len_code;
  logic               valid;
  logic [CNT_W-1:0]   elem_count;
  logic [MAX_LEN-1:0] elem_mask;
  logic               len_ovf;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pmask_expand #(.PRED_W(PRED_W), .VL_W(VL_W), .MAX_LEN(MAX_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pred(pred), .pred_inv(pred_inv),
    .vl(vl), .len_code(len_code), .valid(valid), .elem_count(elem_count),
    .elem_mask(elem_mask), .len_ovf(len_ovf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent model from R1-style code table, R2..R6.
  function automatic void model(input logic [PRED_W-1:0] p, input logic inv,
                                input int v, input logic [2:0] code,
                                output int cnt, output logic ovf,
                                output logic [MAX_LEN-1:0] m);
    int k;
    int raw;
    logic [PRED_W-1:0] pe;
    pe = inv ? ~p : p;
    case (code)
      3'b000: begin k = 1; raw = 1; end
      3'b111: begin k = 1; raw = 4; end
      3'b001: begin k = 1;  raw = v;      end
      3'b010: begin k = 2;  raw = v * 2;  end
      3'b011: begin k = 3;  raw = v * 3;  end
      3'b100: begin k = 4;  raw = v * 4;  end
      3'b101: begin k = 8;  raw = v * 8;  end
      default: begin k = 16; raw = v * 16; end
    endcase
    ovf = raw > MAX_LEN;
    cnt = ovf ? MAX_LEN : raw;
    m = '0;
    for (int e = 0; e < MAX_LEN; e++)
      if (e < cnt && (e / k) < PRED_W) m[e] = pe[e / k];
  endfunction

  task automatic run(input string req, input logic [PRED_W-1:0] p, input logic inv,
                     input int v, input logic [2:0] code);
    int ecnt;
    logic eovf;
    logic [MAX_LEN-1:0] emask;
    logic [MAX_LEN-1:0] hold_mask;
    model(p, inv, v, code, ecnt, eovf, emask);
    @(negedge clk);
    pred = p; pred_inv = inv; vl = VL_W'(v); len_code = code; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " valid"}, 64'(valid), 64'(1));
    chk({req, " count"}, 64'(elem_count), 64'(ecnt));
    chk({req, " ovf"},   64'(len_ovf), 64'(eovf));
    chk({req, " mask"},  64'(elem_mask), 64'(emask));
    // Change inputs without start: outputs must hold (R7).
    hold_mask = elem_mask;
    pred = ~p; pred_inv = ~inv; vl = VL_W'(v + 1); len_code = code + 3'd1;
    @(negedge clk);
    chk("R7 valid drops", 64'(valid), 64'(0));
    chk("R7 mask held",   64'(elem_mask), 64'(hold_mask));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20190118));
    rst_n = 1'b0; start = 1'b0; pred = '0; pred_inv = 1'b0; vl = '0; len_code = '0;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8 valid", 64'(valid), 64'(0));
    chk("R8 count", 64'(elem_count), 64'(0));
    chk("R8 mask",  64'(elem_mask), 64'(0));
    chk("R8 ovf",   64'(len_ovf), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R4: VL=3, pred 0x5 inverted, factor 4 -> elements 4..7 of 12
    run("R2 R4 worked example", 64'h5, 1'b1, 3, 3'b100);
    chk("R2 example mask", 64'(elem_mask), 64'h0000_0000_0000_00F0);
    // R1: each code
    for (int c = 0; c < 8; c++) run("R1 code sweep", 64'hA5C3_0F96_1234_8E71, 1'b0, 5, 3'(c));
    // R3: fixed codes ignore VL
    run("R3 fixed4 vl0", 64'hB, 1'b0, 0, 3'b111);
    run("R3 fixed4 vlmax", 64'h6, 1'b1, 127, 3'b111);
    run("R3 single", 64'h1, 1'b0, 90, 3'b000);
    // R5: VL zero
    run("R5 vl zero", '1, 1'b0, 0, 3'b011);
    // R6: clamp edges
    run("R6 x3 at 63", 64'hFFFF_0000_5555_AAAA, 1'b0, 21, 3'b011);
    run("R6 x3 over", 64'hFFFF_0000_5555_AAAA, 1'b1, 22, 3'b011);
    run("R6 x16 at 64", 64'h9, 1'b0, 4, 3'b110);
    run("R6 x16 over", 64'h9, 1'b0, 5, 3'b110);
    run("R6 vl1 max", 64'h8000_0000_0000_0001, 1'b0, 127, 3'b001);
    run("R6 vl1 64", 64'h8000_0000_0000_0001, 1'b1, 64, 3'b001);
    // Random: VL weighted toward the clamp band
    for (int i = 0; i < 300; i++) begin
      logic [PRED_W-1:0] p;
      int v;
      p = {$urandom, $urandom};
      v = ($urandom % 2) ? int'($urandom % 32) : int'($urandom % 128);
      run("R2 R4 R5 R6 random", p, 1'($urandom), v, 3'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule